// File: doc/BRIEF.md
# SPI Slave Transmit Channel with Transmit-Only Mode

This block is one slave channel of an SPI port. The external master owns the serial clock and the active-low chip select. The channel shifts words out on the slave output line in SPI mode 0, most significant bit first. Host software loads outgoing words through a simple write port into a transmit buffer. A configuration bit picks the buffer size. With the bit set, the buffer is a FIFO of `DEPTH` words. With the bit clear, the FIFO is bypassed and the buffer holds a single word.

A two-bit transfer-mode input selects the channel's role. The full-duplex code lets incoming words reach a receive register and raise receive events. The transmit-only code keeps shifting bits in on the data-in line, but those bits never reach software: the receive register, receive events and the receive read request all stay quiet. The end-of-word event is raised only in single-word (bypass) mode, because with the FIFO enabled it carries no useful information.

Each of five events has a sticky status bit that is cleared by writing 1 to it. Each status bit has an enable bit. The single interrupt line is the OR of the enabled, pending bits. It follows the enables with no clock delay, so software can either take interrupts or poll the status bits.

The serial clock, chip select and data-in pins are sampled in the system clock domain. The system clock therefore has to run several times faster than the serial clock.

Top module: `spi_txo_slave`

## Requirements
- R1: After reset, all status bits read 0, `irq` is 0, `tx_empty` is 1, `spi_miso_oe` is 0 and `rx_data` is 0.
- R2: Each word is shifted out MSB first in SPI mode 0. When chip select is asserted, the first bit is driven before the first rising serial-clock edge. Each later bit changes after a falling edge, so it is stable at the rising edge where the master samples it.
- R3: Buffered words go out in write order, back to back, within one chip-select period. A word is removed from the buffer only when the master samples its first bit.
- R4: If the buffer is empty when a word's first bit is sampled, that word is sent as all zeros and status bit 1 (transmit underflow) is set.
- R5: Status bit 2 (end of word) is set each time a word completes, and only while `cfg_fifo_en` is 0. It is never set while `cfg_fifo_en` is 1.
- R6: With `cfg_fifo_en`=1 the buffer accepts up to `DEPTH` words. With `cfg_fifo_en`=0 it accepts one word. A write to a full buffer is dropped.
- R7: Status bit 0 (transmit empty) is set when the last buffered word is taken. The `tx_empty` output is high whenever the buffer holds no word.
- R8: With `cfg_xfer_mode`=2'b00, each completed word's data-in bits (MSB first) appear on `rx_data` and set status bit 3 (receive full). `rx_req` then follows bit 3. A word that completes while bit 3 is still set also sets status bit 4 (receive overrun).
- R9: With `cfg_xfer_mode`=2'b10 (transmit only), status bits 3 and 4 are never set, `rx_req` stays 0, and `rx_data` keeps its value.
- R10: Writing 1 to a bit of `irq_clear` clears that status bit. An event on the same cycle wins over the clear, and the bit stays set.
- R11: `irq` equals the OR of (status AND `irq_enable`), with no clock delay. Clearing an enable drops `irq` at once, and the status bit still reads 1.
- R12: While chip select is high, `spi_miso_oe` is 0 and the bit counter is held at 0. A word cut short by chip select going high is abandoned, and the next selection starts a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_xfer_mode | input | 2 | Transfer mode: 2'b00 full duplex, 2'b10 transmit only |
| cfg_fifo_en | input | 1 | 1: `DEPTH`-word FIFO; 0: single-word buffer |
| wr_valid | input | 1 | Host write strobe into the transmit buffer |
| wr_data | input | DW | Host write word |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (tri-state control) |
| rx_data | output | DW | Last received word (full-duplex mode only) |
| rx_req | output | 1 | Receive read request |
| tx_empty | output | 1 | Transmit buffer holds no word |
| irq_enable | input | 5 | Per-event interrupt enables |
| irq_clear | input | 5 | Write-1-to-clear strobes for the status bits |
| irq_status | output | 5 | Sticky event status bits |
| irq | output | 1 | Interrupt line |

## Verification
A change on a serial pin takes effect on the third rising system-clock edge after it: two synchronizer flops, then the registered action. Status, `rx_data` and `tx_empty` therefore settle within three cycles of a serial edge. The bench holds every serial-clock phase for eight cycles and samples all outputs on falling system-clock edges, so each sample falls well after settling. `irq` is combinational from the status and enable bits. Its masking check samples one nanosecond after the enable changes, inside the same cycle. The clear-versus-event check is timed to the exact cycle: the clear strobe is raised during the cycle that ends at the third edge after a serial-clock rise, so that it coincides with the underflow event.

// File: rtl/spi_txo_pkg.sv
`timescale 1ns/1ps
package spi_txo_pkg;
  localparam int NEV    = 5;
  localparam int EV_TXE = 0;
  localparam int EV_UNF = 1;
  localparam int EV_EOT = 2;
  localparam int EV_RXF = 3;
  localparam int EV_ROV = 4;

  typedef logic [NEV-1:0] ev_t;

  typedef enum logic [1:0] {
    XM_DUPLEX = 2'b00,
    XM_RXSIDE = 2'b01,
    XM_TXONLY = 2'b10,
    XM_SPARE  = 2'b11
  } xmode_e;

  // Receive-side events exist in every mode except transmit only.
  function automatic logic rx_events_on(input logic [1:0] mode);
    return xmode_e'(mode) != XM_TXONLY;
  endfunction

  // Number of words the transmit buffer may hold.
  function automatic int unsigned buf_cap(input logic fifo_en, input int unsigned depth);
    return fifo_en ? depth : 1;
  endfunction

  // Sticky status update: write-1-to-clear, a new event wins.
  function automatic ev_t status_next(input ev_t cur, input ev_t clr, input ev_t ev);
    return (cur & ~clr) | ev;
  endfunction
endpackage

// File: rtl/spi_txo_sync.sv
`timescale 1ns/1ps
module spi_txo_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST[i];
        s2 <= RST[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/spi_txo_fifo.sv
`timescale 1ns/1ps
module spi_txo_fifo import spi_txo_pkg::*; #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            pop,
  output logic [DW-1:0]   head,
  output logic [CNTW-1:0] count,
  output logic            empty,
  output logic            drained
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          accept, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  assign accept  = wr_en && (32'(count) < buf_cap(fifo_en, DEPTH));
  assign do_pop  = pop && (count != '0);
  assign head    = mem[rp];
  assign empty   = (count == '0);
  assign drained = do_pop && (count == CNTW'(1)) && !accept;

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (accept) wp <= ptr_inc(wp);
      if (do_pop) rp <= ptr_inc(rp);
      count <= count + CNTW'(accept) - CNTW'(do_pop);
    end
  end
endmodule

// File: rtl/spi_txo_shifter.sv
`timescale 1ns/1ps
module spi_txo_shifter #(
  parameter  int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          cs_act,
  input  logic          mosi_s,
  input  logic [DW-1:0] head,
  input  logic          have_data,
  output logic          miso,
  output logic          fifo_pop,
  output logic          unf_ev,
  output logic          word_done,
  output logic [DW-1:0] rx_word,
  output logic [CW-1:0] bit_cnt
);
  logic          sclk_q, cs_q;
  logic          rise, fall, cs_start, first_rise;
  logic          have_word, pend_load;
  logic [DW-1:0] tx_sh, rx_sh;

  assign rise       = sclk_s & ~sclk_q;
  assign fall       = ~sclk_s & sclk_q;
  assign cs_start   = cs_act & ~cs_q;
  assign first_rise = cs_act & ~cs_start & rise & (bit_cnt == '0);
  assign word_done  = cs_act & ~cs_start & rise & (bit_cnt == CW'(DW - 1));
  assign fifo_pop   = first_rise & have_word;
  assign unf_ev     = first_rise & ~have_word;
  assign rx_word    = {rx_sh[DW-2:0], mosi_s};
  assign miso       = tx_sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cs_q      <= 1'b0;
      bit_cnt   <= '0;
      have_word <= 1'b0;
      pend_load <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_act;
      if (!cs_act) begin
        bit_cnt   <= '0;
        pend_load <= 1'b0;
      end else if (cs_start) begin
        // Peek the buffer head; it is consumed at the first sampled bit.
        tx_sh     <= have_data ? head : '0;
        have_word <= have_data;
        bit_cnt   <= '0;
      end else if (rise) begin
        rx_sh   <= rx_word;
        bit_cnt <= (bit_cnt == CW'(DW - 1)) ? '0 : bit_cnt + CW'(1);
        if (bit_cnt == CW'(DW - 1)) pend_load <= 1'b1;
      end else if (fall) begin
        if (pend_load) begin
          tx_sh     <= have_data ? head : '0;
          have_word <= have_data;
          pend_load <= 1'b0;
        end else if (bit_cnt != '0) begin
          tx_sh <= {tx_sh[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_txo_irq.sv
`timescale 1ns/1ps
module spi_txo_irq import spi_txo_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  ev_t  ev,
  input  ev_t  clr,
  input  ev_t  en,
  output ev_t  status,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_next(status, clr, ev);
  end

  assign irq = |(status & en);
endmodule

// File: rtl/spi_txo_slave.sv
`timescale 1ns/1ps
module spi_txo_slave import spi_txo_pkg::*; #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DW),
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_xfer_mode,
  input  logic           cfg_fifo_en,
  input  logic           wr_valid,
  input  logic [DW-1:0]  wr_data,
  input  logic           spi_sclk,
  input  logic           spi_cs_n,
  input  logic           spi_mosi,
  output logic           spi_miso,
  output logic           spi_miso_oe,
  output logic [DW-1:0]  rx_data,
  output logic           rx_req,
  output logic           tx_empty,
  input  logic [NEV-1:0] irq_enable,
  input  logic [NEV-1:0] irq_clear,
  output logic [NEV-1:0] irq_status,
  output logic           irq
);
  logic            sclk_s, cs_n_s, mosi_s, cs_act, rx_on;
  logic [DW-1:0]   head, rx_word;
  logic [CNTW-1:0] fifo_count;
  logic            fifo_empty, fifo_pop, drained, unf_ev, word_done;
  logic [CW-1:0]   bit_cnt;
  ev_t             ev_vec;

  spi_txo_sync #(.W(3), .RST(3'b010)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({spi_sclk, spi_cs_n, spi_mosi}),
    .q   ({sclk_s, cs_n_s, mosi_s})
  );

  assign cs_act = ~cs_n_s;
  assign rx_on  = rx_events_on(cfg_xfer_mode);

  spi_txo_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (cfg_fifo_en),
    .wr_en   (wr_valid),
    .wr_data (wr_data),
    .pop     (fifo_pop),
    .head    (head),
    .count   (fifo_count),
    .empty   (fifo_empty),
    .drained (drained)
  );

  spi_txo_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .cs_act    (cs_act),
    .mosi_s    (mosi_s),
    .head      (head),
    .have_data (~fifo_empty),
    .miso      (spi_miso),
    .fifo_pop  (fifo_pop),
    .unf_ev    (unf_ev),
    .word_done (word_done),
    .rx_word   (rx_word),
    .bit_cnt   (bit_cnt)
  );

  always_comb begin
    ev_vec         = '0;
    ev_vec[EV_TXE] = drained;
    ev_vec[EV_UNF] = unf_ev;
    ev_vec[EV_EOT] = word_done & ~cfg_fifo_en;
    ev_vec[EV_RXF] = word_done & rx_on;
    ev_vec[EV_ROV] = word_done & rx_on & irq_status[EV_RXF] & ~irq_clear[EV_RXF];
  end

  spi_txo_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev_vec),
    .clr    (irq_clear),
    .en     (irq_enable),
    .status (irq_status),
    .irq    (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rx_data <= '0;
    else if (word_done & rx_on) rx_data <= rx_word;
  end

  assign rx_req      = irq_status[EV_RXF] & rx_on;
  assign tx_empty    = fifo_empty;
  assign spi_miso_oe = cs_act;
endmodule

// File: rtl/spi_txo_chk.sv
`timescale 1ns/1ps
module spi_txo_chk import spi_txo_pkg::*; #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DW),
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_xfer_mode,
  input logic            cfg_fifo_en,
  input logic            irq,
  input logic [NEV-1:0]  irq_enable,
  input logic [NEV-1:0]  irq_status,
  input logic            rx_req,
  input logic            spi_miso_oe,
  input logic [NEV-1:0]  ev_vec,
  input logic [CW-1:0]   bit_cnt,
  input logic            cs_act,
  input logic [CNTW-1:0] fifo_count,
  input logic            fifo_pop
);
  // R5
  eot_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[EV_EOT]) |-> !$past(cfg_fifo_en));

  // R9
  txonly_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_status[EV_RXF]) || $rose(irq_status[EV_ROV])) |-> ($past(cfg_xfer_mode) != 2'b10));

  // R9
  txonly_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_xfer_mode == 2'b10) |-> !rx_req);

  // R10
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_vec) & ~irq_status) == '0));

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|irq_status) && (|irq_enable)));

  // R12
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0));

  // R12
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !spi_miso_oe);

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_count) <= DEPTH);

  // R3
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_count != '0));
endmodule

bind spi_txo_slave spi_txo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_xfer_mode (cfg_xfer_mode),
  .cfg_fifo_en   (cfg_fifo_en),
  .irq           (irq),
  .irq_enable    (irq_enable),
  .irq_status    (irq_status),
  .rx_req        (rx_req),
  .spi_miso_oe   (spi_miso_oe),
  .ev_vec        (ev_vec),
  .bit_cnt       (bit_cnt),
  .cs_act        (cs_act),
  .fifo_count    (fifo_count),
  .fifo_pop      (fifo_pop)
);

// File: tb/spi_txo_slave_test.sv
`timescale 1ns/1ps
module spi_txo_slave_test;
  import spi_txo_pkg::*;
  localparam int DW = 8, DEPTH = 8, HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]     cfg_xfer_mode = 2'b00;
  logic           cfg_fifo_en = 1'b1, wr_valid = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic           spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic           spi_miso, spi_miso_oe, rx_req, tx_empty, irq;
  logic [DW-1:0]  rx_data;
  logic [NEV-1:0] irq_enable = '0, irq_clear = '0, irq_status;

  spi_txo_slave #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk, .rst_n, .cfg_xfer_mode, .cfg_fifo_en, .wr_valid, .wr_data,
    .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso, .spi_miso_oe,
    .rx_data, .rx_req, .tx_empty, .irq_enable, .irq_clear, .irq_status, .irq
  );

  int checks = 0, fails = 0;
  logic [DW-1:0]  q[$];
  logic [NEV-1:0] exp_st = '0;
  logic [DW-1:0]  exp_rx = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int cap(input logic fe);
    return fe ? DEPTH : 1;
  endfunction

  function automatic logic irq_model(input logic [NEV-1:0] st, input logic [NEV-1:0] en);
    return |(st & en);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [DW-1:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
    if (q.size() < cap(cfg_fifo_en)) q.push_back(d);
  endtask

  task automatic clear(input logic [NEV-1:0] m);
    @(negedge clk); irq_clear = m;
    @(negedge clk); irq_clear = '0;
    exp_st &= ~m;
  endtask

  // Master side: n words in one chip-select period, mode 0.
  task automatic xfer(input int n, input logic [DW-1:0] mo0);
    logic [DW-1:0] got, exp, mo;
    got = '0;
    @(negedge clk); spi_mosi = mo0[DW-1]; spi_cs_n = 1'b0; idle(HALF);
    for (int w = 0; w < n; w++) begin
      mo = mo0 + DW'(w * 37);
      if (q.size() > 0) begin
        exp = q.pop_front();
        if (q.size() == 0) exp_st[EV_TXE] = 1'b1;
      end else begin
        exp = '0;
        exp_st[EV_UNF] = 1'b1;
      end
      for (int b = DW - 1; b >= 0; b--) begin
        if (!(w == 0 && b == DW - 1)) begin
          spi_sclk = 1'b0; spi_mosi = mo[b]; idle(HALF);
        end
        got[b] = spi_miso;
        spi_sclk = 1'b1; idle(HALF);
      end
      chk("R2 R3 R4 word on miso", 32'(got), 32'(exp));
      if (!cfg_fifo_en) exp_st[EV_EOT] = 1'b1;
      if (cfg_xfer_mode != 2'b10) begin
        if (exp_st[EV_RXF]) exp_st[EV_ROV] = 1'b1;
        exp_st[EV_RXF] = 1'b1;
        exp_rx = mo;
      end
    end
    spi_sclk = 1'b0; idle(HALF);
    spi_cs_n = 1'b1; idle(HALF);
  endtask

  task automatic check_all();
    chk("R4 R5 R7 R8 R9 status", 32'(irq_status), 32'(exp_st));
    chk("R8 R9 rx_data", 32'(rx_data), 32'(exp_rx));
    chk("R8 R9 rx_req", 32'(rx_req), 32'(exp_st[EV_RXF] && cfg_xfer_mode != 2'b10));
    chk("R6 R7 tx_empty", 32'(tx_empty), 32'(q.size() == 0));
    chk("R11 irq", 32'(irq), 32'(irq_model(exp_st, irq_enable)));
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    int nw, nx;
    void'($urandom(32'd4242));
    idle(5); rst_n = 1'b1; idle(2);

    // R1 reset state
    chk("R1 status", 32'(irq_status), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_empty", 32'(tx_empty), 1);
    chk("R1 miso_oe", 32'(spi_miso_oe), 0);
    chk("R1 rx_data", 32'(rx_data), 0);

    // R6 FIFO capacity: ten writes, eight kept, last two words underflow
    for (int i = 0; i < 10; i++) host_write(DW'(8'hA0 + i));
    chk("R6 tx_empty after fill", 32'(tx_empty), 0);
    xfer(10, 8'h11);
    check_all();
    clear('1);

    // R6 bypass: one word kept; R5 end-of-word set
    cfg_fifo_en = 1'b0;
    host_write(8'h55); host_write(8'h66);
    xfer(2, 8'h3A);
    check_all();
    clear('1);

    // R9 transmit only: no receive activity, rx_data unchanged
    cfg_xfer_mode = 2'b10;
    host_write(8'hC3);
    xfer(2, 8'h5E);
    check_all();
    clear('1);
    cfg_xfer_mode = 2'b00;

    // R11 masking is immediate, status stays readable
    host_write(8'h81);
    xfer(1, 8'h24);
    @(negedge clk); irq_enable = '0; irq_enable[EV_EOT] = 1'b1;
    #1 chk("R11 irq raised", 32'(irq), 1);
    @(negedge clk); irq_enable = '0;
    #1 chk("R11 irq masked", 32'(irq), 0);
    chk("R11 status kept", 32'(irq_status[EV_EOT]), 1);
    clear('1);

    // R10 event beats clear in the same cycle; R12 aborted word
    cfg_fifo_en = 1'b1;
    xfer(1, 8'h0F);
    chk("R4 underflow set", 32'(irq_status[EV_UNF]), 1);
    @(negedge clk); spi_cs_n = 1'b0; idle(HALF);
    spi_sclk = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); irq_clear = '0; irq_clear[EV_UNF] = 1'b1;
    @(negedge clk); irq_clear = '0;
    chk("R10 event beats clear", 32'(irq_status[EV_UNF]), 1);
    idle(HALF); spi_sclk = 1'b0; idle(HALF);
    spi_cs_n = 1'b1; idle(HALF);
    chk("R12 miso_oe idle", 32'(spi_miso_oe), 0);
    clear('1);
    chk("R10 clear works", 32'(irq_status), 0);
    host_write(8'h3C);
    xfer(1, 8'h81);
    check_all();
    clear('1);

    // Constrained random rounds
    for (int r = 0; r < 24; r++) begin
      @(negedge clk);
      cfg_fifo_en   = 1'($urandom % 2);
      cfg_xfer_mode = ($urandom % 2) ? 2'b10 : 2'b00;
      irq_enable    = NEV'($urandom);
      nw = int'($urandom % (cap(cfg_fifo_en) + 2));
      for (int i = 0; i < nw; i++) host_write(DW'($urandom));
      nx = 1 + int'($urandom % 3);
      xfer(nx, DW'($urandom));
      check_all();
      if ($urandom % 2) begin
        clear(NEV'($urandom));
        check_all();
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule